// File: doc/BRIEF.md
# Framed Response Receiver

This block receives response characters from a slow serial daisy chain and rebuilds the 16-bit response words plus two in-band status bits from them. Each character starts with a low start bit. Six data bits follow, least significant first. Then come a word-alignment flag, an even parity bit and two stop bits. The line is sampled in the middle of each bit, using a 16x oversampling tick taken from the system clock by a parameterised divider.

Three characters make one word. The first character carries the flag and, in its two upper data bits, the two status bits that feed the interrupt levels. Every character is checked for parity and stop bits. Every word is checked for flag alignment. A finished character waits in a one-deep holding register until the word assembler takes it. If a character completes while that register is still occupied, this is an overrun.

Only error-free words are offered on the inbound FIFO write port. A full FIFO stalls the finished word. Parity and overrun faults also raise a transmission-error pulse. Framing faults do not raise it.

Top module: `rspFrameRx`

## Requirements
- R1: A character is a low start bit, data bits d0..d5 (d0 first), a flag bit, a parity bit and two stop bits. Each bit lasts 16*TICK_DIV clocks and is sampled near its middle. A start bit that is high again at its middle is ignored.
- R2: Parity is even over the six data bits, the flag and the parity bit. A violation gives a one-clock errParity pulse and a one-clock txErr pulse. It drops the character and discards any partly built word.
- R3: A stop bit sampled low is a framing error. It gives a one-clock errFrame pulse, drops the character and discards any partly built word. A stop error takes priority over a parity error on the same character.
- R4: A flag value of 1 marks the first character of a word. An unflagged character at word start gives errFrame and is dropped. A flagged character in the middle of a word gives errFrame, discards the partial word, and becomes the first character of a new word.
- R5: For characters c1, c2, c3 the word is {c1[3:0], c2[5:0], c3[5:0]}. statHi takes c1[5] and statLo takes c1[4]. Both are updated in the clock cycle after the word's wrEn cycle and hold their value otherwise.
- R6: wrEn is high for exactly one clock for each complete error-free word, with the word on wrData. wrEn is never high while fifoFull is high. A word blocked by fifoFull is held and is written once fifoFull falls.
- R7: A character that completes while the previous one is still held unconsumed gives a one-clock errOverrun pulse and a one-clock txErr pulse. The new character, the held character and any partial word are discarded. An already complete word that is waiting is still written.
- R8: After reset, wrEn, wrData, statHi, statLo and all error outputs are low.
- R9: At most one of errParity, errFrame and errOverrun is high in any clock. txErr never pulses for a framing error alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxLine | input | 1 | Serial response line, idle high |
| fifoFull | input | 1 | Inbound FIFO cannot accept a word |
| wrEn | output | 1 | FIFO write strobe |
| wrData | output | 16 | Response word to write |
| statHi | output | 1 | High-priority status bit of the last written word |
| statLo | output | 1 | Low-priority status bit of the last written word |
| errParity | output | 1 | Parity error pulse |
| errFrame | output | 1 | Framing error pulse (stop bit or flag alignment) |
| errOverrun | output | 1 | Overrun error pulse |
| txErr | output | 1 | Transmission error pulse (parity or overrun) |

## Verification
The assertions check on every cycle that:
- no write happens while the FIFO is full;
- writes and error indications are single-clock pulses;
- the error kinds never coincide;
- a framing fault alone never raises the transmission error;
- the status bits change only after a write.

Only the bench's scenarios can show the rest, by comparing counts and values after driving real serial frames:
- that the right word and status bits come out of the three characters;
- that a bad parity or a bad stop bit discards the partial word;
- that a stray flag re-aligns onto a new word;
- that an overrun drops the held character while a stalled word still reaches the FIFO.

// File: rtl/rspRxPkg.sv
package rspRxPkg;
  localparam int CHAR_BITS  = 6;
  localparam int STAT_BITS  = 2;
  localparam int WORD_BITS  = 16;
  localparam int WORD_CHARS = 3;
  // bits shifted after the start bit: data, flag, parity, two stops
  localparam int FRAME_BITS = CHAR_BITS + 4;
  localparam int SLOT_W     = $clog2(WORD_CHARS);

  typedef struct packed {
    logic              shiftIn;
    logic              loadHold;
    logic              takeChar;
    logic [SLOT_W-1:0] slot;
    logic              writeOut;
  } rxStrobe_t;
endpackage

// File: rtl/rxDatapath.sv
module rxDatapath
  import rspRxPkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxLine,
  input  rxStrobe_t            stb,
  output logic                 rxBit,
  output logic                 tick,
  output logic                 holdFlag,
  output logic                 parityOk,
  output logic                 stopOk,
  output logic [WORD_BITS-1:0] wrData,
  output logic                 statHi,
  output logic                 statLo
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TOP_W = CHAR_BITS - STAT_BITS;

  logic [1:0]            syncQ;
  logic [DIV_W-1:0]      divCnt;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [CHAR_BITS-1:0]  holdData;
  logic                  holdFlagQ;
  logic [STAT_BITS-1:0]  statQ;
  logic [WORD_BITS-1:0]  wordQ;

  assign tick     = (divCnt == DIV_W'(TICK_DIV - 1));
  assign rxBit    = syncQ[1];
  assign holdFlag = holdFlagQ;
  assign parityOk = ~^shiftQ[CHAR_BITS+1:0];
  assign stopOk   = &shiftQ[FRAME_BITS-1:CHAR_BITS+2];
  assign wrData   = wordQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ     <= 2'b11;
      divCnt    <= '0;
      shiftQ    <= '0;
      holdData  <= '0;
      holdFlagQ <= 1'b0;
      statQ     <= '0;
      wordQ     <= '0;
      statHi    <= 1'b0;
      statLo    <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (tick) divCnt <= '0;
      else      divCnt <= divCnt + 1'b1;
      if (stb.shiftIn) shiftQ <= {syncQ[1], shiftQ[FRAME_BITS-1:1]};
      if (stb.loadHold) begin
        holdData  <= shiftQ[CHAR_BITS-1:0];
        holdFlagQ <= shiftQ[CHAR_BITS];
      end
      if (stb.takeChar) begin
        case (stb.slot)
          SLOT_W'(0): begin
            statQ <= holdData[CHAR_BITS-1 -: STAT_BITS];
            wordQ[WORD_BITS-1 -: TOP_W] <= holdData[TOP_W-1:0];
          end
          SLOT_W'(1): wordQ[2*CHAR_BITS-1 -: CHAR_BITS] <= holdData;
          default:    wordQ[CHAR_BITS-1:0] <= holdData;
        endcase
      end
      if (stb.writeOut) {statHi, statLo} <= statQ;
    end
  end
endmodule

// File: rtl/rxControl.sv
module rxControl
  import rspRxPkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rxBit,
  input  logic      tick,
  input  logic      holdFlag,
  input  logic      parityOk,
  input  logic      stopOk,
  input  logic      fifoFull,
  output rxStrobe_t stb,
  output logic      wrEn,
  output logic      errParity,
  output logic      errFrame,
  output logic      errOverrun,
  output logic      txErr
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} rxState_t;

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              charEvt, holdValid, pending;
  logic [SLOT_W-1:0] slot;
  logic              midTick, lastTick, goodChar, consume, overrun, flagErr;

  always_comb begin
    midTick  = tick && (tickCnt == CNT_W'(OVERSAMPLE/2 - 1));
    lastTick = tick && (tickCnt == CNT_W'(OVERSAMPLE - 1));
    goodChar = charEvt && stopOk && parityOk;
    consume  = holdValid && !pending;
    overrun  = goodChar && holdValid && !consume;
    flagErr  = consume && (holdFlag != (slot == '0));
    wrEn     = pending && !fifoFull;
    stb.shiftIn  = (state == S_DATA) && lastTick;
    stb.loadHold = goodChar && !overrun;
    stb.takeChar = consume && (holdFlag || slot != '0);
    stb.slot     = holdFlag ? '0 : slot;
    stb.writeOut = wrEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      tickCnt    <= '0;
      bitCnt     <= '0;
      charEvt    <= 1'b0;
      holdValid  <= 1'b0;
      pending    <= 1'b0;
      slot       <= '0;
      errParity  <= 1'b0;
      errFrame   <= 1'b0;
      errOverrun <= 1'b0;
      txErr      <= 1'b0;
    end else begin
      charEvt <= 1'b0;
      case (state)
        S_IDLE: if (!rxBit) begin
          state   <= S_START;
          tickCnt <= '0;
        end
        S_START: if (tick) begin
          if (midTick) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxBit ? S_IDLE : S_DATA;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (lastTick) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
              state   <= S_IDLE;
              charEvt <= 1'b1;
            end
          end else tickCnt <= tickCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase

      if (stb.loadHold)          holdValid <= 1'b1;
      else if (consume || overrun) holdValid <= 1'b0;

      if (wrEn) pending <= 1'b0;
      if (consume) begin
        if (holdFlag)                            slot <= SLOT_W'(1);
        else if (slot == SLOT_W'(WORD_CHARS-1)) begin
          slot    <= '0;
          pending <= 1'b1;
        end else if (slot != '0)                 slot <= slot + 1'b1;
      end
      if ((charEvt && !goodChar) || overrun) slot <= '0;

      errParity  <= charEvt && stopOk && !parityOk;
      errFrame   <= (charEvt && !stopOk) || flagErr;
      errOverrun <= overrun;
      txErr      <= (charEvt && stopOk && !parityOk) || overrun;
    end
  end
endmodule

// File: rtl/rspFrameRx.sv
module rspFrameRx
  import rspRxPkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rxLine,
  input  logic        fifoFull,
  output logic        wrEn,
  output logic [15:0] wrData,
  output logic        statHi,
  output logic        statLo,
  output logic        errParity,
  output logic        errFrame,
  output logic        errOverrun,
  output logic        txErr
);
  rxStrobe_t stb;
  logic rxBit, tick, holdFlag, parityOk, stopOk;

  rxDatapath #(.TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rst(rst), .rxLine(rxLine), .stb(stb),
    .rxBit(rxBit), .tick(tick), .holdFlag(holdFlag),
    .parityOk(parityOk), .stopOk(stopOk),
    .wrData(wrData), .statHi(statHi), .statLo(statLo)
  );

  rxControl #(.OVERSAMPLE(OVERSAMPLE)) u_ctl (
    .clk(clk), .rst(rst), .rxBit(rxBit), .tick(tick),
    .holdFlag(holdFlag), .parityOk(parityOk), .stopOk(stopOk),
    .fifoFull(fifoFull), .stb(stb), .wrEn(wrEn),
    .errParity(errParity), .errFrame(errFrame),
    .errOverrun(errOverrun), .txErr(txErr)
  );
endmodule

// File: rtl/rspFrameRxChk.sv
module rspFrameRxChk (
  input logic clk,
  input logic rst,
  input logic fifoFull,
  input logic wrEn,
  input logic statHi,
  input logic statLo,
  input logic errParity,
  input logic errFrame,
  input logic errOverrun,
  input logic txErr
);
  AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (rst) wrEn |-> !fifoFull); // R6
  AST_WR_ONE_CLK: assert property (@(posedge clk) disable iff (rst) wrEn |=> !wrEn); // R6
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst) !wrEn |=> $stable({statHi, statLo})); // R5
  AST_PAR_PULSE: assert property (@(posedge clk) disable iff (rst) errParity |=> !errParity); // R2
  AST_FRM_PULSE: assert property (@(posedge clk) disable iff (rst) errFrame |=> !errFrame); // R3
  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (rst) errOverrun |=> !errOverrun); // R7
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({errParity, errFrame, errOverrun})); // R9
  AST_FRM_NO_TX: assert property (@(posedge clk) disable iff (rst) (errFrame && !errParity && !errOverrun) |-> !txErr); // R9
endmodule

bind rspFrameRx rspFrameRxChk u_chk (
  .clk(clk), .rst(rst), .fifoFull(fifoFull), .wrEn(wrEn),
  .statHi(statHi), .statLo(statLo), .errParity(errParity),
  .errFrame(errFrame), .errOverrun(errOverrun), .txErr(txErr)
);

// File: tb/rspFrameRx_tb.sv
module rspFrameRx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  typedef struct packed {
    logic [5:0]  c0, c1, c2;
    logic [2:0]  flg;
    logic [2:0]  badPar;
    logic        expWr;
    logic [15:0] expWord;
    logic [1:0]  expStat;
    logic [1:0]  expPar;
    logic [1:0]  expFrm;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{6'h2D, 6'h15, 6'h2A, 3'b100, 3'b000, 1'b1, 16'hD56A, 2'b10, 2'd0, 2'd0},
    '{6'h13, 6'h3F, 6'h00, 3'b100, 3'b000, 1'b1, 16'h3FC0, 2'b01, 2'd0, 2'd0},
    '{6'h3C, 6'h01, 6'h3E, 3'b100, 3'b000, 1'b1, 16'hC07E, 2'b11, 2'd0, 2'd0},
    '{6'h2D, 6'h15, 6'h2A, 3'b100, 3'b010, 1'b0, 16'h0000, 2'b00, 2'd1, 2'd1},
    '{6'h2D, 6'h15, 6'h2A, 3'b000, 3'b000, 1'b0, 16'h0000, 2'b00, 2'd0, 2'd3},
    '{6'h00, 6'h2B, 6'h15, 3'b100, 3'b000, 1'b1, 16'h0AD5, 2'b00, 2'd0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1, rxLine = 1'b1, fifoFull = 1'b0;
  logic wrEn, statHi, statLo, errParity, errFrame, errOverrun, txErr;
  logic [15:0] wrData;

  int nChecks = 0, nFail = 0;
  int nWr = 0, nPar = 0, nFrm = 0, nOvr = 0, nTx = 0;
  logic [15:0] lastWord = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rspFrameRx #(.TICK_DIV(TICK_DIV)) u_dut (
    .clk(clk), .rst(rst), .rxLine(rxLine), .fifoFull(fifoFull),
    .wrEn(wrEn), .wrData(wrData), .statHi(statHi), .statLo(statLo),
    .errParity(errParity), .errFrame(errFrame),
    .errOverrun(errOverrun), .txErr(txErr)
  );

  always @(negedge clk) if (!rst) begin
    if (wrEn) begin nWr++; lastWord = wrData; end
    if (errParity)  nPar++;
    if (errFrame)   nFrm++;
    if (errOverrun) nOvr++;
    if (txErr)      nTx++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendChar(input logic [5:0] d, input logic flag,
                          input logic badPar, input logic badStop);
    logic [10:0] bits;
    bits = {1'b1, ~badStop, (^{flag, d}) ^ badPar, flag, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxLine = bits[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (2*BIT_CLKS) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int w0, p0, f0, o0, t0;
    repeat (5) @(negedge clk);
    check(wrEn == 1'b0 && wrData == 16'h0, "R8 write port", {wrEn, wrData}, 0);
    check({statHi, statLo} == 2'b00, "R8 status", {statHi, statLo}, 0);
    check({errParity, errFrame, errOverrun, txErr} == 4'b0, "R8 errors",
          {errParity, errFrame, errOverrun, txErr}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // table of frames: R1 R2 R4 R5 R9
    for (int v = 0; v < NVEC; v++) begin
      w0 = nWr; p0 = nPar; f0 = nFrm; o0 = nOvr; t0 = nTx;
      sendChar(VECS[v].c0, VECS[v].flg[2], VECS[v].badPar[2], 1'b0);
      sendChar(VECS[v].c1, VECS[v].flg[1], VECS[v].badPar[1], 1'b0);
      sendChar(VECS[v].c2, VECS[v].flg[0], VECS[v].badPar[0], 1'b0);
      check(nWr - w0 == int'(VECS[v].expWr), "R6 write count", nWr - w0, VECS[v].expWr);
      if (VECS[v].expWr) begin
        check(lastWord == VECS[v].expWord, "R1 R5 word", lastWord, VECS[v].expWord);
        check({statHi, statLo} == VECS[v].expStat, "R5 status", {statHi, statLo}, VECS[v].expStat);
      end
      check(nPar - p0 == int'(VECS[v].expPar), "R2 parity errors", nPar - p0, VECS[v].expPar);
      check(nFrm - f0 == int'(VECS[v].expFrm), "R4 framing errors", nFrm - f0, VECS[v].expFrm);
      check(nTx - t0 == int'(VECS[v].expPar), "R9 txErr count", nTx - t0, VECS[v].expPar);
      check(nOvr == o0, "R9 no overrun", nOvr - o0, 0);
    end

    // R1: a short low glitch is not a start bit
    w0 = nWr; f0 = nFrm;
    rxLine = 1'b0; repeat (BIT_CLKS/8) @(negedge clk);
    rxLine = 1'b1; repeat (2*BIT_CLKS) @(negedge clk);
    sendChar(6'h11, 1'b1, 1'b0, 1'b0);
    sendChar(6'h22, 1'b0, 1'b0, 1'b0);
    sendChar(6'h33, 1'b0, 1'b0, 1'b0);
    check(nFrm == f0 && nWr - w0 == 1, "R1 glitch ignored", nFrm - f0, 0);
    check(lastWord == 16'h18B3, "R1 word after glitch", lastWord, 16'h18B3);

    // R3: bad stop bit discards the partial word, stop beats parity
    w0 = nWr; f0 = nFrm; p0 = nPar;
    sendChar(6'h2D, 1'b1, 1'b0, 1'b0);
    sendChar(6'h15, 1'b0, 1'b1, 1'b1);
    check(nFrm - f0 == 1 && nPar == p0, "R3 stop error", nFrm - f0, 1);
    sendChar(6'h11, 1'b1, 1'b0, 1'b0);
    sendChar(6'h22, 1'b0, 1'b0, 1'b0);
    sendChar(6'h33, 1'b0, 1'b0, 1'b0);
    check(nWr - w0 == 1 && nFrm - f0 == 1, "R3 clean word after", nWr - w0, 1);
    check(lastWord == 16'h18B3, "R3 word", lastWord, 16'h18B3);

    // R4: flagged character mid-word starts a new word
    w0 = nWr; f0 = nFrm;
    sendChar(6'h05, 1'b1, 1'b0, 1'b0);
    sendChar(6'h2A, 1'b1, 1'b0, 1'b0);
    sendChar(6'h0F, 1'b0, 1'b0, 1'b0);
    sendChar(6'h30, 1'b0, 1'b0, 1'b0);
    check(nFrm - f0 == 1, "R4 resync frame error", nFrm - f0, 1);
    check(nWr - w0 == 1 && lastWord == 16'hA3F0, "R4 resync word", lastWord, 16'hA3F0);
    check({statHi, statLo} == 2'b10, "R4 R5 resync status", {statHi, statLo}, 2'b10);

    // R6 R7: full FIFO stalls a word, extra characters overrun
    w0 = nWr; o0 = nOvr; t0 = nTx; f0 = nFrm;
    fifoFull = 1'b1;
    sendChar(6'h2D, 1'b1, 1'b0, 1'b0);
    sendChar(6'h15, 1'b0, 1'b0, 1'b0);
    sendChar(6'h2A, 1'b0, 1'b0, 1'b0);
    check(nWr == w0, "R6 no write while full", nWr - w0, 0);
    sendChar(6'h01, 1'b1, 1'b0, 1'b0);
    sendChar(6'h02, 1'b0, 1'b0, 1'b0);
    check(nOvr - o0 == 1, "R7 overrun pulse", nOvr - o0, 1);
    check(nTx - t0 == 1, "R7 txErr on overrun", nTx - t0, 1);
    check(nWr == w0, "R6 still stalled", nWr - w0, 0);
    fifoFull = 1'b0;
    repeat (10) @(negedge clk);
    check(nWr - w0 == 1 && lastWord == 16'hD56A, "R6 stalled word written", lastWord, 16'hD56A);
    check({statHi, statLo} == 2'b10, "R5 status after stall", {statHi, statLo}, 2'b10);
    sendChar(6'h13, 1'b1, 1'b0, 1'b0);
    sendChar(6'h3F, 1'b0, 1'b0, 1'b0);
    sendChar(6'h00, 1'b0, 1'b0, 1'b0);
    check(nFrm == f0, "R7 held character discarded", nFrm - f0, 0);
    check(nWr - w0 == 2 && lastWord == 16'h3FC0, "R7 next word", lastWord, 16'h3FC0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule